// File: doc/BRIEF.md
# Method Dispatcher with Macro Upload

This block sits at the front of a command-processing engine. Each cycle it may accept one method write: a word index, a 32-bit data word and a flag that marks the final write of a command entry. Indices inside the register space are stored in a register file, which has a combinational read port for the macro execution core. A few indices have side effects. Two pointer/load pairs fill the instruction RAM and the macro start-address RAM with auto-incrementing pointers. One word selects how a shadow copy of the register file behaves. One word pulses a syncpoint increment.

Indices above the register space are macro calls. An even index selects a macro slot. Every macro write, even or odd, streams its data word to the execution core as an argument. The write that carries the last flag raises a start request. The request gives the slot's start offset from the start-address RAM and the number of arguments collected. The request waits while the core reports busy, and no new method is accepted until the request is taken.

The shadow copy can record register writes (track modes), ignore them (passthrough), or replay them. In replay mode the recorded value replaces the incoming data word for the RAM-load side effects.

Top module: `method_dispatch`

## Requirements
- R1: After reset the instruction pointer (word 0x45) and the start pointer (word 0x47) read 0. The shadow mode is track (0). `mth_ready_o` is 1. `start_valid_o`, `arg_push_o`, `sync_incr_o`, `ovf_iram_o` and `ovf_start_o` are all 0.
- R2: An accepted write with index below REG_WORDS (default 0xE00) is stored, and `rd_data_o` returns it for that address from the next cycle. The read port returns 0 for any address at or above REG_WORDS. A write at exactly REG_WORDS is dropped: nothing is stored, no argument is pushed, and the argument count is unchanged.
- R3: Every accepted write with index above REG_WORDS pushes its data word on `arg_push_o`/`arg_data_o` in the next cycle. An even index sets the slot to ((index - REG_WORDS) >> 1) mod 128. An odd index leaves the slot as it is.
- R4: A macro write with `mth_last_i` set raises `start_valid_o`. `start_ofs_o` is the start-RAM entry of the current slot, and `start_cnt_o` is the number of macro writes since the previous start, this one included. The slot and the count then return to 0.
- R5: While `mac_busy_i` is 1, a pending start stays pending with `start_valid_o` low. While a start is pending, `mth_ready_o` is 0. The request is taken in the first cycle in which `start_valid_o` is 1.
- R6: A write to word 0x46 stores the data in the instruction RAM at the pointer held at word 0x45, then increments the pointer. The pointer value reads back at word 0x45, and `iram_data_o` returns the entry at `iram_addr_i`.
- R7: A write to word 0x48 stores the data (truncated to the instruction-RAM address width) in the 128-entry start-address RAM at the pointer held at word 0x47, then increments that pointer. The pointer reads back at word 0x47.
- R8: A load to either RAM while its pointer is at or past the RAM depth stores nothing and leaves the pointer unchanged. It also raises the matching overflow output (`ovf_iram_o` or `ovf_start_o`) for exactly one cycle.
- R9: A write to word 0x49 sets the shadow mode from data bits [1:0], always from the raw data: 0 track, 1 track-with-filter, 2 passthrough, 3 replay. In modes 0 and 1 each register write is also recorded in the shadow. In modes 2 and 3 it is not.
- R10: In mode 3, a load to word 0x46 or 0x48 uses the shadow value recorded for that word instead of the incoming data. The register file still stores the incoming data.
- R11: A write to word 0xB2 pulses `sync_incr_o` for one cycle in the next cycle, with `sync_id_o` equal to data bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mth_valid_i | input | 1 | Method write present |
| mth_ready_o | output | 1 | Method write can be accepted |
| mth_idx_i | input | IDX_W | Method word index |
| mth_data_i | input | 32 | Method data word |
| mth_last_i | input | 1 | Last write of the command entry |
| rd_addr_i | input | IDX_W | Register-space read address |
| rd_data_o | output | 32 | Register-space read data |
| iram_addr_i | input | IRAM_AW | Instruction RAM read address |
| iram_data_o | output | 32 | Instruction RAM read data |
| mac_busy_i | input | 1 | Execution core is running a macro |
| start_valid_o | output | 1 | Macro start request |
| start_ofs_o | output | IRAM_AW | Start offset of the selected macro |
| start_cnt_o | output | CNT_W | Number of arguments of the request |
| arg_push_o | output | 1 | Argument word valid |
| arg_data_o | output | 32 | Argument word |
| sync_incr_o | output | 1 | Syncpoint increment pulse |
| sync_id_o | output | SYNC_W | Syncpoint to increment |
| ovf_iram_o | output | 1 | Instruction RAM load overflow |
| ovf_start_o | output | 1 | Start-address RAM load overflow |

## Verification
The assertions check, on every cycle, several local rules. A RAM load must either advance its pointer or raise a one-cycle overflow and hold it. A pending start must survive every busy cycle. The last macro write must leave the slot and count cleared. No method may be accepted while a start is pending. A syncpoint write must produce its pulse and id one cycle later. Track modes must record each register write. Other behaviour needs ordered scenarios from the bench, because it depends on history. That includes slot selection across odd writes and the modulo-128 wrap, the argument count of each start, the offset looked up from earlier start-RAM loads, and replay substituting a value recorded several writes before while passthrough writes leave it untouched.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;
  localparam int unsigned W_IPTR  = 32'h45;
  localparam int unsigned W_ILOAD = 32'h46;
  localparam int unsigned W_SPTR  = 32'h47;
  localparam int unsigned W_SLOAD = 32'h48;
  localparam int unsigned W_SHCTL = 32'h49;
  localparam int unsigned W_SYNC  = 32'hB2;

  typedef enum logic [1:0] {
    SH_TRACK     = 2'd0,
    SH_TRACK_FLT = 2'd1,
    SH_PASS      = 2'd2,
    SH_REPLAY    = 2'd3
  } sh_mode_e;

  typedef struct packed {
    logic reg_wr;
    logic mac_wr;
    logic even;
    logic set_iptr;
    logic ld_iram;
    logic set_sptr;
    logic ld_start;
    logic set_mode;
    logic sync;
  } dec_t;
endpackage

// File: rtl/mdisp_decode.sv
module mdisp_decode
  import mdisp_pkg::*;
#(
  parameter int unsigned REG_WORDS = 32'hE00,
  parameter int unsigned IDX_W     = 13
) (
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  output dec_t             dec_o
);
  localparam logic [IDX_W-1:0] REG_LIM = IDX_W'(REG_WORDS);

  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      if (idx_i < REG_LIM) begin
        dec_o.reg_wr   = 1'b1;
        dec_o.set_iptr = (idx_i == IDX_W'(W_IPTR));
        dec_o.ld_iram  = (idx_i == IDX_W'(W_ILOAD));
        dec_o.set_sptr = (idx_i == IDX_W'(W_SPTR));
        dec_o.ld_start = (idx_i == IDX_W'(W_SLOAD));
        dec_o.set_mode = (idx_i == IDX_W'(W_SHCTL));
        dec_o.sync     = (idx_i == IDX_W'(W_SYNC));
      end else if (idx_i > REG_LIM) begin
        dec_o.mac_wr = 1'b1;
        dec_o.even   = ~idx_i[0];
      end
    end
  end
endmodule

// File: rtl/mdisp_regbank.sv
module mdisp_regbank
  import mdisp_pkg::*;
#(
  parameter int unsigned REG_WORDS = 32'hE00,
  parameter int unsigned IDX_W     = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      data_i,
  input  logic             mode_wr_i,
  output logic [31:0]      eff_o,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [31:0]      rd_data_o
);
  localparam int unsigned AW = $clog2(REG_WORDS);

  logic [31:0] regs_q   [REG_WORDS];
  logic [31:0] shadow_q [REG_WORDS];
  sh_mode_e    mode_q;
  logic [AW-1:0] wa;
  logic          rec;

  assign wa  = AW'(idx_i);
  assign rec = (mode_q == SH_TRACK) || (mode_q == SH_TRACK_FLT);

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      regs_q[wa] <= data_i;
      if (rec) shadow_q[wa] <= data_i;
    end
  end

  // shadow control itself always takes the raw data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= SH_TRACK;
    else if (mode_wr_i) mode_q <= sh_mode_e'(data_i[1:0]);
  end

  assign eff_o     = (mode_q == SH_REPLAY) ? shadow_q[wa] : data_i;
  assign rd_data_o = (rd_addr_i < IDX_W'(REG_WORDS)) ? regs_q[AW'(rd_addr_i)] : 32'd0;

  AST_TRACK_RECORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (mode_q == SH_TRACK || mode_q == SH_TRACK_FLT)
    |=> shadow_q[$past(wa)] == $past(data_i)); // R9

  AST_REG_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wa)] == $past(data_i)); // R2
endmodule

// File: rtl/mdisp_ldchan.sv
module mdisp_ldchan #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_ptr_i,
  input  logic          ld_i,
  input  logic [31:0]   ptr_data_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [31:0]   ptr_o,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [31:0]   ptr_q;
  logic          ovf_q;
  logic          room;

  assign room = (ptr_q < 32'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (set_ptr_i)  ptr_q <= ptr_data_i;
      else if (ld_i) begin
        if (room) ptr_q <= ptr_q + 32'd1;
        else      ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ld_i && room) mem_q[AW'(ptr_q)] <= ld_data_i;
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = mem_q[raddr_i];
  assign ovf_o   = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && !set_ptr_i && !room |=> ovf_o && $stable(ptr_q)); // R8

  AST_LOAD_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && !set_ptr_i && room |=> !ovf_o && ptr_q == $past(ptr_q) + 32'd1); // R6
endmodule

// File: rtl/mdisp_macro.sv
module mdisp_macro #(
  parameter int unsigned REG_WORDS = 32'hE00,
  parameter int unsigned IDX_W     = 13,
  parameter int unsigned SLOTS     = 128,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned OFS_W     = 8,
  localparam int unsigned SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mac_wr_i,
  input  logic              even_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [31:0]       data_i,
  input  logic              busy_i,
  output logic [SLOT_W-1:0] slot_o,
  input  logic [OFS_W-1:0]  ofs_lookup_i,
  output logic              pend_o,
  output logic              start_valid_o,
  output logic [OFS_W-1:0]  start_ofs_o,
  output logic [CNT_W-1:0]  start_cnt_o,
  output logic              arg_push_o,
  output logic [31:0]       arg_data_o
);
  logic [IDX_W-1:0]  rel;
  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_out_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              pend_q, push_q;
  logic [31:0]       arg_q;

  assign rel      = idx_i - IDX_W'(REG_WORDS);
  assign slot_nxt = (mac_wr_i && even_i) ? SLOT_W'(rel >> 1) : slot_q;
  assign slot_o   = slot_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '0;
      cnt_q     <= '0;
      cnt_out_q <= '0;
      ofs_q     <= '0;
      pend_q    <= 1'b0;
      push_q    <= 1'b0;
      arg_q     <= '0;
    end else begin
      push_q <= mac_wr_i;
      if (start_valid_o) pend_q <= 1'b0;
      if (mac_wr_i) begin
        arg_q <= data_i;
        if (last_i) begin
          pend_q    <= 1'b1;
          ofs_q     <= ofs_lookup_i;
          cnt_out_q <= cnt_q + CNT_W'(1);
          slot_q    <= '0;
          cnt_q     <= '0;
        end else begin
          slot_q <= slot_nxt;
          cnt_q  <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign pend_o        = pend_q;
  assign start_valid_o = pend_q && !busy_i;
  assign start_ofs_o   = ofs_q;
  assign start_cnt_o   = cnt_out_q;
  assign arg_push_o    = push_q;
  assign arg_data_o    = arg_q;

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && busy_i |=> pend_q); // R5

  AST_CLEAR_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_wr_i && last_i |=> pend_q && cnt_q == '0 && slot_q == '0); // R4

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !mac_wr_i); // R5

  AST_ARG_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_wr_i |=> arg_push_o && arg_data_o == $past(data_i)); // R3
endmodule

// File: rtl/method_dispatch.sv
module method_dispatch
  import mdisp_pkg::*;
#(
  parameter int unsigned REG_WORDS   = 32'hE00,
  parameter int unsigned IDX_W       = 13,
  parameter int unsigned IRAM_DEPTH  = 256,
  parameter int unsigned MACRO_SLOTS = 128,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_W      = 12,
  localparam int unsigned IRAM_AW    = $clog2(IRAM_DEPTH),
  localparam int unsigned SLOT_W     = $clog2(MACRO_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mth_valid_i,
  output logic               mth_ready_o,
  input  logic [IDX_W-1:0]   mth_idx_i,
  input  logic [31:0]        mth_data_i,
  input  logic               mth_last_i,
  input  logic [IDX_W-1:0]   rd_addr_i,
  output logic [31:0]        rd_data_o,
  input  logic [IRAM_AW-1:0] iram_addr_i,
  output logic [31:0]        iram_data_o,
  input  logic               mac_busy_i,
  output logic               start_valid_o,
  output logic [IRAM_AW-1:0] start_ofs_o,
  output logic [CNT_W-1:0]   start_cnt_o,
  output logic               arg_push_o,
  output logic [31:0]        arg_data_o,
  output logic               sync_incr_o,
  output logic [SYNC_W-1:0]  sync_id_o,
  output logic               ovf_iram_o,
  output logic               ovf_start_o
);
  dec_t               dec;
  logic               pend;
  logic [31:0]        eff;
  logic [31:0]        bank_rd, iptr, sptr;
  logic [SLOT_W-1:0]  slot;
  logic [IRAM_AW-1:0] slot_ofs;
  logic               sync_q;
  logic [SYNC_W-1:0]  sync_id_q;

  assign mth_ready_o = !pend;

  mdisp_decode #(.REG_WORDS(REG_WORDS), .IDX_W(IDX_W)) u_dec (
    .valid_i (mth_valid_i && !pend),
    .idx_i   (mth_idx_i),
    .dec_o   (dec)
  );

  mdisp_regbank #(.REG_WORDS(REG_WORDS), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i      (dec.reg_wr),
    .idx_i     (mth_idx_i),
    .data_i    (mth_data_i),
    .mode_wr_i (dec.set_mode),
    .eff_o     (eff),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (bank_rd)
  );

  mdisp_ldchan #(.DEPTH(IRAM_DEPTH), .DW(32)) u_iram (
    .clk_i, .rst_ni,
    .set_ptr_i  (dec.set_iptr),
    .ld_i       (dec.ld_iram),
    .ptr_data_i (mth_data_i),
    .ld_data_i  (eff),
    .ptr_o      (iptr),
    .raddr_i    (iram_addr_i),
    .rdata_o    (iram_data_o),
    .ovf_o      (ovf_iram_o)
  );

  mdisp_ldchan #(.DEPTH(MACRO_SLOTS), .DW(IRAM_AW)) u_start (
    .clk_i, .rst_ni,
    .set_ptr_i  (dec.set_sptr),
    .ld_i       (dec.ld_start),
    .ptr_data_i (mth_data_i),
    .ld_data_i  (IRAM_AW'(eff)),
    .ptr_o      (sptr),
    .raddr_i    (slot),
    .rdata_o    (slot_ofs),
    .ovf_o      (ovf_start_o)
  );

  mdisp_macro #(
    .REG_WORDS(REG_WORDS), .IDX_W(IDX_W), .SLOTS(MACRO_SLOTS),
    .CNT_W(CNT_W), .OFS_W(IRAM_AW)
  ) u_mac (
    .clk_i, .rst_ni,
    .mac_wr_i      (dec.mac_wr),
    .even_i        (dec.even),
    .last_i        (mth_last_i),
    .idx_i         (mth_idx_i),
    .data_i        (mth_data_i),
    .busy_i        (mac_busy_i),
    .slot_o        (slot),
    .ofs_lookup_i  (slot_ofs),
    .pend_o        (pend),
    .start_valid_o (start_valid_o),
    .start_ofs_o   (start_ofs_o),
    .start_cnt_o   (start_cnt_o),
    .arg_push_o    (arg_push_o),
    .arg_data_o    (arg_data_o)
  );

  // pointers live in the load channels; expose them at their word addresses
  always_comb begin
    if (rd_addr_i == IDX_W'(W_IPTR))      rd_data_o = iptr;
    else if (rd_addr_i == IDX_W'(W_SPTR)) rd_data_o = sptr;
    else                                  rd_data_o = bank_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      sync_id_q <= '0;
    end else begin
      sync_q <= dec.sync;
      if (dec.sync) sync_id_q <= mth_data_i[SYNC_W-1:0];
    end
  end

  assign sync_incr_o = sync_q;
  assign sync_id_o   = sync_id_q;

  AST_SYNC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mth_valid_i && mth_ready_o && mth_idx_i == IDX_W'(W_SYNC)
    |=> sync_incr_o && sync_id_o == $past(mth_data_i[SYNC_W-1:0])); // R11

  AST_EDGE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mth_valid_i && mth_ready_o && mth_idx_i == IDX_W'(REG_WORDS) |=> !arg_push_o); // R2
endmodule

// File: tb/tb_method_dispatch.sv
`timescale 1ns/1ps
module tb_method_dispatch;
  localparam int IDX_W = 13;
  localparam int REGW  = 'hE00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, last = 1'b0, busy = 1'b0;
  logic [12:0] idx = '0, rd_addr = '0;
  logic [31:0] data = '0;
  logic [7:0]  iram_addr = '0;
  logic        ready, start_valid, arg_push, sync_incr, ovf_i, ovf_s;
  logic [31:0] rd_data, iram_data, arg_data;
  logic [7:0]  start_ofs;
  logic [15:0] start_cnt;
  logic [11:0] sync_id;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_arg[$];
  int          exp_ofs[$];
  int          exp_cnt[$];
  int          sm[128];
  int          cur_slot = 0, cur_cnt = 0;

  always #2.5 clk = ~clk;

  method_dispatch dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mth_valid_i(valid), .mth_ready_o(ready), .mth_idx_i(idx),
    .mth_data_i(data), .mth_last_i(last),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .iram_addr_i(iram_addr), .iram_data_o(iram_data),
    .mac_busy_i(busy),
    .start_valid_o(start_valid), .start_ofs_o(start_ofs), .start_cnt_o(start_cnt),
    .arg_push_o(arg_push), .arg_data_o(arg_data),
    .sync_incr_o(sync_incr), .sync_id_o(sync_id),
    .ovf_iram_o(ovf_i), .ovf_start_o(ovf_s)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one method write, scoreboard updated for macro writes
  task automatic wr(input int i, input logic [31:0] d, input bit l);
    @(negedge clk);
    while (!ready) @(negedge clk);
    if (i > REGW) begin
      exp_arg.push_back(d);
      cur_cnt++;
      if ((i % 2) == 0) cur_slot = ((i - REGW) >> 1) % 128;
      if (l) begin
        exp_ofs.push_back(sm[cur_slot]);
        exp_cnt.push_back(cur_cnt);
        cur_slot = 0;
        cur_cnt  = 0;
      end
    end
    valid = 1'b1; idx = 13'(i); data = d; last = l;
    @(negedge clk);
    valid = 1'b0; last = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_addr = 13'(a);
    #1;
    chk(rd_data == e, tag, rd_data, e);
  endtask

  task automatic iram_chk(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    iram_addr = 8'(a);
    #1;
    chk(iram_data == e, tag, iram_data, e);
  endtask

  // monitor: pops expected arguments and start requests as they appear
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (arg_push) begin
        if (exp_arg.size() == 0) chk(1'b0, "R3 unexpected argument", arg_data, 32'd0);
        else begin
          logic [31:0] e;
          e = exp_arg.pop_front();
          chk(arg_data == e, "R3 argument data", arg_data, e);
        end
      end
      if (start_valid) begin
        if (exp_ofs.size() == 0) chk(1'b0, "R4 unexpected start", {24'd0, start_ofs}, 32'd0);
        else begin
          int eo, ec;
          eo = exp_ofs.pop_front();
          ec = exp_cnt.pop_front();
          chk(start_ofs == 8'(eo), "R4 start offset", {24'd0, start_ofs}, 32'(eo));
          chk(start_cnt == 16'(ec), "R4 start count", {16'd0, start_cnt}, 32'(ec));
        end
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(ready == 1'b1, "R1 ready", {31'd0, ready}, 32'd1);
    chk(start_valid == 1'b0, "R1 start idle", {31'd0, start_valid}, 32'd0);
    chk(arg_push == 1'b0, "R1 no argument", {31'd0, arg_push}, 32'd0);
    chk(sync_incr == 1'b0 && ovf_i == 1'b0 && ovf_s == 1'b0, "R1 pulses low",
        {29'd0, sync_incr, ovf_i, ovf_s}, 32'd0);
    rd_chk('h45, 32'd0, "R1 iram pointer");
    rd_chk('h47, 32'd0, "R1 start pointer");

    // R2 register storage and read port range
    wr('h10, 32'hDEADBEEF, 1'b0);
    wr('hDFF, 32'h5555AAAA, 1'b0);
    rd_chk('h10, 32'hDEADBEEF, "R2 store low word");
    rd_chk('hDFF, 32'h5555AAAA, "R2 store top word");
    rd_chk('hE05, 32'd0, "R2 read above space");

    // R7 start RAM fill for slots 0..3
    wr('h47, 32'd0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      wr('h48, 32'(10 * (k + 1)), 1'b0);
      sm[k] = 10 * (k + 1);
    end
    rd_chk('h47, 32'd4, "R7 start pointer advanced");

    // R3/R4 macro calls
    wr('hE02, 32'h11, 1'b1);                 // slot 1
    wr('hE06, 32'hA, 1'b0);                  // slot 3
    wr('hE07, 32'hB, 1'b0);
    wr('hE07, 32'hC, 1'b1);
    wr('hE01, 32'h5, 1'b1);                  // odd only: slot 0 after clear
    wr('hF04, 32'h7, 1'b0);                  // R3 wrap: 130 mod 128 = slot 2
    wr('hF05, 32'h8, 1'b1);

    // R2 index at the boundary is dropped
    wr(REGW, 32'h99, 1'b0);
    wr('hE03, 32'h6, 1'b1);                  // count stays 1, slot 0
    rd_chk(REGW - 1, 32'h5555AAAA, "R2 boundary write left top word");

    // R5 busy holds the start and blocks input
    @(negedge clk); busy = 1'b1;
    wr('hE04, 32'h21, 1'b1);                 // slot 2
    repeat (3) @(negedge clk);
    #1;
    chk(start_valid == 1'b0, "R5 start held while busy", {31'd0, start_valid}, 32'd0);
    chk(ready == 1'b0, "R5 not ready while pending", {31'd0, ready}, 32'd0);
    chk(exp_ofs.size() == 1, "R5 request outstanding", 32'(exp_ofs.size()), 32'd1);
    @(negedge clk); busy = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(exp_ofs.size() == 0, "R5 request taken after busy", 32'(exp_ofs.size()), 32'd0);
    chk(ready == 1'b1, "R5 ready again", {31'd0, ready}, 32'd1);

    // R6/R9/R10 instruction RAM with shadow modes
    wr('h45, 32'd0, 1'b0);
    wr('h46, 32'hAAAA0001, 1'b0);            // mode 0 records
    wr('h49, 32'd2, 1'b0);
    wr('h46, 32'hCCCC0002, 1'b0);            // passthrough: not recorded
    wr('h49, 32'd3, 1'b0);
    wr('h46, 32'hDDDD0003, 1'b0);            // replay
    wr('h49, 32'd1, 1'b0);
    wr('h46, 32'hEEEE0004, 1'b0);            // mode 1 records
    wr('h49, 32'd3, 1'b0);
    wr('h46, 32'hFFFF0005, 1'b0);
    iram_chk(0, 32'hAAAA0001, "R6 iram load");
    iram_chk(1, 32'hCCCC0002, "R9 passthrough load");
    iram_chk(2, 32'hAAAA0001, "R10 replay uses recorded value");
    iram_chk(4, 32'hEEEE0004, "R9 track-with-filter recorded");
    rd_chk('h46, 32'hFFFF0005, "R10 register keeps raw data");
    rd_chk('h45, 32'd5, "R6 pointer readback");
    wr('h49, 32'd0, 1'b0);

    // R8 instruction RAM overflow
    wr('h45, 32'd255, 1'b0);
    wr('h46, 32'h12345678, 1'b0);
    #1;
    chk(ovf_i == 1'b0, "R8 last entry fits", {31'd0, ovf_i}, 32'd0);
    wr('h46, 32'h87654321, 1'b0);
    #1;
    chk(ovf_i == 1'b1, "R8 iram overflow pulse", {31'd0, ovf_i}, 32'd1);
    @(negedge clk); #1;
    chk(ovf_i == 1'b0, "R8 pulse one cycle", {31'd0, ovf_i}, 32'd0);
    rd_chk('h45, 32'd256, "R8 pointer held");
    iram_chk(255, 32'h12345678, "R8 entry not overwritten");

    // R8 start RAM overflow at 128 entries
    wr('h47, 32'd127, 1'b0);
    wr('h48, 32'd50, 1'b0);
    sm[127] = 50;
    wr('h48, 32'd60, 1'b0);
    #1;
    chk(ovf_s == 1'b1, "R8 start overflow pulse", {31'd0, ovf_s}, 32'd1);
    rd_chk('h47, 32'd128, "R8 start pointer held");
    wr('hEFE, 32'h3, 1'b1);                  // slot 127 -> offset 50
    wr('h10FE, 32'h4, 1'b1);                 // (0x2FE>>1)%128 = 127

    // R11 syncpoint
    wr('hB2, 32'h12345ABC, 1'b0);
    #1;
    chk(sync_incr == 1'b1, "R11 sync pulse", {31'd0, sync_incr}, 32'd1);
    chk(sync_id == 12'hABC, "R11 sync id", {20'd0, sync_id}, 32'hABC);
    @(negedge clk); #1;
    chk(sync_incr == 1'b0, "R11 pulse one cycle", {31'd0, sync_incr}, 32'd0);

    repeat (4) @(negedge clk);
    chk(exp_arg.size() == 0 && exp_ofs.size() == 0, "R4 scoreboard drained",
        32'(exp_arg.size() + exp_ofs.size()), 32'd0);
    finish_run();
  end
endmodule